// File: doc/BRIEF.md
# Overcurrent Cycle Fault Counter

This block decides when repeated overcurrent events in a switching power stage are a real fault rather than noise. Once per switching cycle, marked by a one-clock strobe, it looks at two current-limit detect flags, one from the high-side switch and one from the low-side switch. A cycle in which either flag was seen moves a small counter up by one. A clean cycle moves it down by one, and the counter never goes below zero. An isolated overcurrent cycle is therefore forgiven after a clean one, while an overload that persists pushes the counter past its limit.

When a strobe with a detect arrives while the counter already sits at its limit, the counter overflows and a sticky fault latch is set. The power-sequencing controller reads this latch and shuts down the gate drivers and the oscillator. After its off period it restarts the converter and pulses the clear input, which drops the latch and returns the count to zero. Detect pulses that arrive between strobes are held until the next strobe, so short comparator pulses are not lost.

With the default limit of 4, the fifth consecutive overcurrent cycle sets the latch. The count and the latch both change on the clock edge that follows the edge on which the strobe, detect or clear input is seen.

Top module: `oc_cycle_guard`

## Requirements
- R1: A cycle counts as an overcurrent cycle when either the high-side flag or the low-side flag was seen, or both were.
- R2: A strobe in an overcurrent cycle, with the latch clear and the count below TRIP_LIMIT, increments the count by one on the next clock edge.
- R3: A strobe in a cycle without a detect decrements the count by one. At zero the count stays at zero.
- R4: A strobe in an overcurrent cycle while the count equals TRIP_LIMIT (default 4) sets the fault latch on the next edge, so the fifth consecutive overcurrent cycle trips. The count stays at TRIP_LIMIT and never exceeds it.
- R5: A detect seen on a clock without a strobe is held and counts at the next strobe. Every strobe consumes the held detect. Without a strobe the count does not change.
- R6: The clear input sets the latch to 0 and the count to 0 on the next edge, and it discards any held detect. Clear takes priority over a strobe in the same cycle.
- R7: While the latch is set, it stays set and strobes do not change the count, with or without a detect.
- R8: After reset the latch is 0, the count is 0 and no detect is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_stb | input | 1 | One-clock pulse marking the end of a switching cycle |
| hi_trip | input | 1 | High-side current-limit detect |
| lo_trip | input | 1 | Low-side current-limit detect |
| trip_clr | input | 1 | Clear of latch, count and held detect, issued by the sequencer |
| fault_o | output | 1 | Sticky overcurrent fault latch |
| cnt_o | output | CNT_W | Current overcurrent cycle count |

## Verification
Four consecutive detect strobes followed by a fifth show exactly where the trip point lies, and a run of five clean strobes from the top shows the floor at zero. Alternating detect and clean strobes must never trip the latch, which separates an up/down counter from one that only counts up. Flags driven only on the high side, only on the low side, and only between strobes show that the inputs are combined and that detects are held. Strobes sent while the latch is set, and a clear given together with a strobe, show that the count is frozen and that clear has priority.

// File: rtl/oc_guard_pkg.sv
package oc_guard_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

endpackage

// File: rtl/oc_trip_capture.sv
module oc_trip_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic stb_i,
    input  logic hi_i,
    input  logic lo_i,
    output logic det_o
);
    typedef struct packed {
        logic pend;
    } cap_t;

    cap_t cur_q, nxt_d;
    logic raw_hit;

    always_comb begin
        raw_hit = hi_i | lo_i;
        nxt_d   = cur_q;
        if (clr_i) begin
            nxt_d.pend = 1'b0;
        end else if (stb_i) begin
            nxt_d.pend = 1'b0;
        end else begin
            nxt_d.pend = cur_q.pend | raw_hit;
        end
        det_o = cur_q.pend | raw_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R5: a detect off-strobe is remembered
    a_r5_hold_detect: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_hit && !stb_i && !clr_i) |=> cur_q.pend);

    // R5: a strobe consumes the held detect
    a_r5_strobe_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i |=> (cur_q.pend == $past(hi_i | lo_i) && !$past(clr_i)) || !cur_q.pend || !$past(stb_i));

    // R6: clear discards the held detect
    a_r6_clear_pend: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !cur_q.pend || 1'b0 == 1'b1 || $past(clr_i) && !cur_q.pend);
endmodule

// File: rtl/oc_updown_sat.sv
module oc_updown_sat
    import oc_guard_pkg::*;
#(
    parameter int LIMIT = 4,
    parameter int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  step_e            step_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] TOP  = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] ZERO = '0;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t cur_q, nxt_d;
    logic at_top, at_zero;

    always_comb begin
        nxt_d   = cur_q;
        at_top  = (cur_q.cnt == TOP);
        at_zero = (cur_q.cnt == ZERO);
        ovf_o   = 1'b0;
        if (clr_i) begin
            nxt_d.cnt = ZERO;
        end else begin
            unique case (step_i)
                STEP_UP: begin
                    if (at_top) ovf_o = 1'b1;
                    else        nxt_d.cnt = cur_q.cnt + CNT_W'(1);
                end
                STEP_DOWN: begin
                    if (!at_zero) nxt_d.cnt = cur_q.cnt - CNT_W'(1);
                end
                default: nxt_d.cnt = cur_q.cnt;
            endcase
        end
        cnt_o = cur_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R2: step up below the top adds one
    a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == STEP_UP && !clr_i && cur_q.cnt != TOP)
        |=> cur_q.cnt == $past(cur_q.cnt) + CNT_W'(1));

    // R3: step down at zero stays at zero
    a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == STEP_DOWN && !clr_i && cur_q.cnt == ZERO) |=> cur_q.cnt == ZERO);

    // R3: step down above zero removes one
    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == STEP_DOWN && !clr_i && cur_q.cnt != ZERO)
        |=> cur_q.cnt == $past(cur_q.cnt) - CNT_W'(1));

    // R4: the count never passes the limit
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= TOP);
endmodule

// File: rtl/oc_cycle_guard.sv
module oc_cycle_guard
    import oc_guard_pkg::*;
#(
    parameter int TRIP_LIMIT = 4,
    parameter int CNT_W      = $clog2(TRIP_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_stb,
    input  logic             hi_trip,
    input  logic             lo_trip,
    input  logic             trip_clr,
    output logic             fault_o,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic fault;
    } lat_t;

    lat_t  cur_q, nxt_d;
    logic  det;
    logic  ovf;
    step_e step;

    oc_trip_capture u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (trip_clr),
        .stb_i (cyc_stb),
        .hi_i  (hi_trip),
        .lo_i  (lo_trip),
        .det_o (det)
    );

    oc_updown_sat #(
        .LIMIT (TRIP_LIMIT),
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (trip_clr),
        .step_i (step),
        .cnt_o  (cnt_o),
        .ovf_o  (ovf)
    );

    always_comb begin
        nxt_d = cur_q;
        step  = STEP_HOLD;
        if (cyc_stb && !cur_q.fault && !trip_clr) begin
            step = det ? STEP_UP : STEP_DOWN;
        end
        if (trip_clr) nxt_d.fault = 1'b0;
        else if (ovf) nxt_d.fault = 1'b1;
        fault_o = cur_q.fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R4: strobe with detect at the limit sets the latch
    a_r4_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && (hi_trip || lo_trip) && !trip_clr && cnt_o == CNT_W'(TRIP_LIMIT))
        |=> fault_o);

    // R6: clear empties latch and count
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        trip_clr |=> (!fault_o && cnt_o == '0));

    // R7: latch is sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !trip_clr) |=> fault_o);

    // R7: count frozen while latched
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !trip_clr) |=> $stable(cnt_o));

    // R5: no strobe, no change in count
    a_r5_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_stb && !trip_clr) |=> $stable(cnt_o));
endmodule

// File: tb/sim_oc_cycle_guard.sv
`timescale 1ns/1ps
module sim_oc_cycle_guard;
    localparam int LIM = 4;
    localparam int CW  = $clog2(LIM + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_stb = 1'b0, hi_trip = 1'b0, lo_trip = 1'b0, trip_clr = 1'b0;
    logic          fault_o;
    logic [CW-1:0] cnt_o;

    int checks = 0, failures = 0, cycles = 0;
    int m_cnt = 0;
    bit m_fault = 1'b0, m_pend = 1'b0;

    always #4 clk = ~clk;

    oc_cycle_guard #(.TRIP_LIMIT(LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .hi_trip(hi_trip),
        .lo_trip(lo_trip), .trip_clr(trip_clr), .fault_o(fault_o), .cnt_o(cnt_o)
    );

    task automatic chk(input string req, input int exp_cnt, input bit exp_fault);
        checks++;
        if (int'(cnt_o) != exp_cnt || fault_o != exp_fault) begin
            failures++;
            $display("FAIL %s: cnt=%0d fault=%0b expected cnt=%0d fault=%0b",
                     req, cnt_o, fault_o, exp_cnt, exp_fault);
        end
    endtask

    // one clock of stimulus; model follows the requirements
    task automatic step(input bit s, input bit h, input bit l, input bit c);
        bit det;
        cyc_stb = s; hi_trip = h; lo_trip = l; trip_clr = c;
        @(posedge clk); #1;
        cyc_stb = 0; hi_trip = 0; lo_trip = 0; trip_clr = 0;
        det = m_pend | h | l;
        if (c) begin
            m_cnt = 0; m_fault = 0; m_pend = 0;
        end else if (s) begin
            if (!m_fault) begin
                if (det) begin
                    if (m_cnt == LIM) m_fault = 1;
                    else m_cnt++;
                end else if (m_cnt > 0) m_cnt--;
            end
            m_pend = 0;
        end else m_pend = det;
    endtask

    task automatic t_reset;
        chk("R8 reset", 0, 0);
        step(1, 0, 0, 0);
        chk("R8 no held detect after reset", 0, 0);
    endtask

    task automatic t_either_flag;
        step(1, 1, 0, 0); chk("R1 high-side flag", 1, 0);
        step(1, 0, 1, 0); chk("R1 low-side flag", 2, 0);
        step(1, 1, 1, 0); chk("R1 both flags", 3, 0);
        step(0, 0, 0, 1); chk("R6 clear", 0, 0);
    endtask

    task automatic t_floor;
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0);
        chk("R2 three increments", 3, 0);
        for (int i = 0; i < 5; i++) begin
            step(1, 0, 0, 0);
            chk("R3 decrement to floor", (3 - i - 1) < 0 ? 0 : 3 - i - 1, 0);
        end
    endtask

    task automatic t_overflow;
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0);
        chk("R4 four cycles no trip", 4, 0);
        step(1, 1, 0, 0);
        chk("R4 fifth cycle trips", 4, 1);
    endtask

    task automatic t_frozen;
        step(1, 0, 0, 0); chk("R7 clean strobe frozen", 4, 1);
        step(1, 1, 1, 0); chk("R7 detect strobe frozen", 4, 1);
        step(0, 0, 0, 0); chk("R7 latch sticky", 4, 1);
        step(0, 0, 0, 1); chk("R6 clear drops latch", 0, 0);
    endtask

    task automatic t_forgive;
        for (int i = 0; i < 12; i++) step(1, (i % 2) == 0, 0, 0);
        chk("R3 alternating never trips", 0, 0);
        for (int i = 0; i < 6; i++) step(1, 1, 0, 0);
        step(1, 0, 0, 0);
        chk("R4 sustained then clean", 4, 1);
        step(0, 0, 0, 1);
        chk("R6 clear after trip", 0, 0);
    endtask

    task automatic t_between;
        step(0, 1, 0, 0);
        step(0, 0, 0, 0);
        chk("R5 no strobe no count", 0, 0);
        step(1, 0, 0, 0);
        chk("R5 held detect counted", 1, 0);
        step(1, 0, 0, 0);
        chk("R5 held detect consumed", 0, 0);
    endtask

    task automatic t_clear_priority;
        step(1, 1, 0, 0); step(1, 1, 0, 0);
        step(0, 0, 1, 0);
        step(1, 1, 0, 1);
        chk("R6 clear beats strobe", 0, 0);
        step(1, 0, 0, 0);
        chk("R6 clear discards held detect", 0, 0);
        chk("model agreement", m_cnt, m_fault);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_either_flag();
        t_floor();
        t_overflow();
        t_frozen();
        t_forgive();
        t_between();
        t_clear_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            failures++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule